// File: doc/BRIEF.md
# Double-buffered byte-loaded converter code register

This block is the digital front end of a 16-bit multiplying converter that sits on an 8-bit processor bus. A processor builds a 16-bit code in two bus writes. Each write puts one byte into one of two 8-bit holding latches, and a select input picks which latch. A separate, gated transfer then copies both holding latches into the 16-bit code register in one step. Because of this, the converter code changes once per complete word and never shows a half-updated value.

All bus inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. A strobe counts as valid only after it has stayed low for `MIN_PULSE_CYCLES` consecutive clock cycles. This count is the minimum pulse width (`MIN_PULSE_NS`, 150 ns by default) divided by the clock period and rounded up, which gives 19 cycles at 8 ns. Shorter glitches on any strobe are discarded. Each completed transfer produces a one-cycle `updated_o` pulse.

Top module: `dac_word_loader`

## Requirements
- R1: After reset, `code_o` is 0x0000, `updated_o` is 0, and both holding latches are zero, so a transfer issued before any load yields 0x0000.
- R2: A qualified write with `upper_sel_i`=1 loads `data_i` into code bits 15:8. With `upper_sel_i`=0 it loads bits 7:0. The two bytes may be written in either order before a transfer.
- R3: While `chip_sel_ni` is high, `load_ni` pulses of any length leave both holding latches unchanged.
- R4: A holding latch takes the data present on the last qualified cycle of the write strobe, and keeps it after the strobe rises, even if `data_i` changes later.
- R5: A transfer happens only while `gate_ni` and `commit_ni` are both low. Either one low on its own changes neither `code_o` nor `updated_o`.
- R6: Loading a holding latch never changes `code_o` by itself.
- R7: A write or transfer strobe that is low for fewer than `MIN_PULSE_CYCLES` (19 at default parameters) consecutive cycles is ignored. A strobe that is low for exactly that many cycles takes effect.
- R8: Each qualified transfer produces exactly one `updated_o` pulse, one cycle wide, within four cycles after the transfer strobes rise.
- R9: A transfer with no new load in between copies the current latches again. The code keeps its value, and the transfer still produces an `updated_o` pulse.
- R10: While a transfer is held open, a qualified write shows up on `code_o` within a few cycles, and that value remains after the transfer closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Bus data byte |
| chip_sel_ni | input | 1 | Chip select, active low; enables the write strobe |
| load_ni | input | 1 | Write strobe into the holding latches, active low |
| upper_sel_i | input | 1 | Byte steering: 1 selects bits 15:8, 0 selects bits 7:0 |
| gate_ni | input | 1 | Transfer enable, active low |
| commit_ni | input | 1 | Transfer strobe, active low |
| code_o | output | 16 | Converter code; bit 15 is the MSB, all ones is full scale |
| updated_o | output | 1 | One-cycle pulse after each completed transfer |

## Verification
A byte load and a word transfer can qualify in the same cycle. When they do, the code register copies the latches as they stood before that cycle's load, and picks up the new byte on the next cycle. The bench provokes this by holding both transfer strobes low for longer than the minimum width and then issuing a full write while the transfer is still open. It judges the result by reading `code_o` once while the transfer is still held and again after it closes. Both reads must equal the reference model's merged word, and exactly one `updated_o` pulse must be counted.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  typedef enum logic {
    SEL_LOWER = 1'b0,
    SEL_UPPER = 1'b1
  } byte_sel_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dacw_sync.sv
module dacw_sync #(
  parameter int               W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {2{RST_VAL[b]}};
      else         stg_q <= {stg_q[0], d_i[b]};
    end
    assign q_o[b] = stg_q[1];
  end
endmodule

// File: rtl/dacw_strobe_qual.sv
// Qualifies an active strobe once it has been active MIN_CYCLES cycles in a row.
module dacw_strobe_qual #(
  parameter int MIN_CYCLES = 19
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic qual_o
);
  localparam int          CW   = (MIN_CYCLES > 2) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!act_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = act_i && (cnt_q == LAST);
endmodule

// File: rtl/dacw_byte_latches.sv
module dacw_byte_latches #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [BYTE_W-1:0]           data_i,
  output logic [NUM_BYTES*BYTE_W-1:0] word_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            byte_q <= '0;
      else if (wr_i && sel_i == SEL_W'(g))    byte_q <= data_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader #(
  parameter int BYTE_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int MIN_PULSE_NS  = 150
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic                chip_sel_ni,
  input  logic                load_ni,
  input  logic                upper_sel_i,
  input  logic                gate_ni,
  input  logic                commit_ni,
  output logic [2*BYTE_W-1:0] code_o,
  output logic                updated_o
);
  import dacw_pkg::*;

  localparam int WORD_W           = 2 * BYTE_W;
  localparam int MIN_PULSE_CYCLES = ceil_div(MIN_PULSE_NS, CLK_PERIOD_NS);
  localparam int SYNC_W           = BYTE_W + 5;
  // strobes idle high, data and select idle low
  localparam logic [SYNC_W-1:0] SYNC_RST = {{(BYTE_W+1){1'b0}}, 4'b1111};

  logic [SYNC_W-1:0] sync_q;
  logic [BYTE_W-1:0] data_s;
  logic              upper_s, cs_s, load_s, gate_s, commit_s;
  logic              wr_act, xfer_act, wr_qual, xfer_qual;
  logic [WORD_W-1:0] latch_word;
  logic [WORD_W-1:0] code_q;
  logic              xfer_qual_r, upd_q;
  byte_sel_e         sel;

  dacw_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data_i, upper_sel_i, chip_sel_ni, load_ni, gate_ni, commit_ni}),
    .q_o   (sync_q)
  );

  assign {data_s, upper_s, cs_s, load_s, gate_s, commit_s} = sync_q;

  assign wr_act   = !cs_s && !load_s;
  assign xfer_act = !gate_s && !commit_s;
  assign sel      = upper_s ? SEL_UPPER : SEL_LOWER;

  dacw_strobe_qual #(.MIN_CYCLES(MIN_PULSE_CYCLES)) u_wr_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (wr_act),
    .qual_o(wr_qual)
  );

  dacw_strobe_qual #(.MIN_CYCLES(MIN_PULSE_CYCLES)) u_xfer_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (xfer_act),
    .qual_o(xfer_qual)
  );

  dacw_byte_latches #(.BYTE_W(BYTE_W), .NUM_BYTES(2), .SEL_W(1)) u_latches (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_qual),
    .sel_i (sel),
    .data_i(data_s),
    .word_o(latch_word)
  );

  // second rank follows the latches only while the transfer is qualified
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= '0;
      xfer_qual_r <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      if (xfer_qual) code_q <= latch_word;
      xfer_qual_r <= xfer_qual;
      upd_q       <= xfer_qual_r && !xfer_qual;
    end
  end

  assign code_o    = code_q;
  assign updated_o = upd_q;
endmodule

// File: rtl/dacw_checker.sv
module dacw_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] code_o,
  input logic              updated_o,
  input logic              wr_qual,
  input logic              xfer_qual,
  input logic              upper_s,
  input logic [WORD_W-1:0] latch_word
);
  localparam int HALF = WORD_W / 2;

  // R6
  code_only_on_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(xfer_qual));

  // R2
  upper_only_on_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(latch_word[WORD_W-1:HALF]) |-> $past(wr_qual && upper_s));

  // R2
  lower_only_on_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(latch_word[HALF-1:0]) |-> $past(wr_qual && !upper_s));

  // R8
  upd_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updated_o |-> ($past(xfer_qual, 2) && !$past(xfer_qual)));

  // R8
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updated_o |=> !updated_o);
endmodule

bind dac_word_loader dacw_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_o    (code_o),
  .updated_o (updated_o),
  .wr_qual   (wr_qual),
  .xfer_qual (xfer_qual),
  .upper_s   (upper_s),
  .latch_word(latch_word)
);

// File: tb/dac_word_loader_test.sv
module dac_word_loader_test;
  localparam int MINC = (150 + 8 - 1) / 8;  // 19 cycles at 8 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data = '0;
  logic        cs_n = 1'b1, load_n = 1'b1, upper = 1'b0, gate_n = 1'b1, commit_n = 1'b1;
  logic [15:0] code;
  logic        updated;

  int checks = 0, failures = 0;
  int upd_cnt = 0, exp_upd = 0;
  bit wide_seen = 0, prev_upd = 0, done = 0;
  logic [7:0]  exp_hi = '0, exp_lo = '0;
  logic [15:0] exp_code = '0;

  always #4 clk = ~clk;

  dac_word_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .chip_sel_ni(cs_n),
    .load_ni(load_n), .upper_sel_i(upper), .gate_ni(gate_n), .commit_ni(commit_n),
    .code_o(code), .updated_o(updated)
  );

  always @(negedge clk) begin
    if (updated === 1'b1) upd_cnt++;
    if (updated === 1'b1 && prev_upd) wide_seen = 1;
    prev_upd = (updated === 1'b1);
  end

  function automatic logic [15:0] merged(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit sel, input logic [7:0] d, input int len, input bit cs_low);
    data = d; upper = sel; cs_n = !cs_low;
    idle(1);
    load_n = 1'b0;
    idle(len);
    load_n = 1'b1;
    idle(3);
    cs_n = 1'b1;
    idle(3);
    if (cs_low && len >= MINC) begin
      if (sel) exp_hi = d; else exp_lo = d;
    end
  endtask

  task automatic do_xfer(input int len, input bit use_gate, input bit use_commit);
    gate_n = !use_gate; commit_n = !use_commit;
    idle(len);
    gate_n = 1'b1; commit_n = 1'b1;
    idle(6);
    if (use_gate && use_commit && len >= MINC) begin
      exp_code = merged(exp_hi, exp_lo);
      exp_upd++;
    end
  endtask

  task automatic check_state(input string req);
    check(req, {16'h0, code}, {16'h0, exp_code});
    check(req, upd_cnt, exp_upd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(5);
    // R1 reset state
    check("R1", {16'h0, code}, 32'h0);
    check("R1", {31'h0, updated}, 32'h0);
    rst_n = 1'b1;
    idle(3);
    do_xfer(MINC + 2, 1, 1);
    check_state("R1");

    // R2 upper then lower; R6 code untouched by loads
    do_write(1, 8'hA5, MINC + 2, 1);
    do_write(0, 8'h3C, MINC + 2, 1);
    check("R6", {16'h0, code}, 32'h0);
    do_xfer(MINC + 2, 1, 1);
    check_state("R2");
    check("R2", {16'h0, code}, 32'hA53C);

    // R2 lower then upper
    do_write(0, 8'h11, MINC + 4, 1);
    do_write(1, 8'h22, MINC + 1, 1);
    do_xfer(MINC + 3, 1, 1);
    check("R2", {16'h0, code}, 32'h2211);

    // R3 chip select high blocks writes
    do_write(1, 8'hFF, MINC + 5, 0);
    do_write(0, 8'hEE, MINC + 5, 0);
    do_xfer(MINC + 2, 1, 1);
    check_state("R3");

    // R5 one transfer strobe alone does nothing
    do_write(0, 8'h99, MINC + 2, 1);
    do_xfer(MINC + 6, 1, 0);
    check_state("R5");
    do_xfer(MINC + 6, 0, 1);
    check_state("R5");
    check("R6", {16'h0, code}, 32'h2211);
    do_xfer(MINC, 1, 1);
    check_state("R5");
    // R9 transfer without a new load
    do_xfer(MINC + 2, 1, 1);
    check_state("R9");
    check("R9", {16'h0, code}, 32'h2299);

    // R7 boundary: one short of the limit rejected, exactly the limit accepted
    do_write(1, 8'h77, MINC - 1, 1);
    do_xfer(MINC + 2, 1, 1);
    check_state("R7");
    do_write(1, 8'h78, MINC, 1);
    do_xfer(MINC - 1, 1, 1);
    check_state("R7");
    do_xfer(MINC, 1, 1);
    check_state("R7");

    // R4 last qualified data is kept, later bus changes ignored
    data = 8'h10; upper = 1'b0; cs_n = 1'b0;
    idle(1);
    load_n = 1'b0;
    idle(MINC + 1);
    data = 8'h20;
    idle(1);
    load_n = 1'b1;
    idle(1);
    data = 8'h30;
    idle(4);
    cs_n = 1'b1;
    idle(3);
    exp_lo = 8'h20;
    do_xfer(MINC + 2, 1, 1);
    check_state("R4");

    // R10 write while a transfer is open
    gate_n = 1'b0; commit_n = 1'b0;
    idle(MINC + 2);
    do_write(0, 8'h5A, MINC + 3, 1);
    check("R10", {16'h0, code}, {16'h0, merged(exp_hi, 8'h5A)});
    gate_n = 1'b1; commit_n = 1'b1;
    idle(6);
    exp_code = merged(exp_hi, exp_lo);
    exp_upd++;
    check_state("R10");

    // mixed random traffic against the model
    for (int i = 0; i < 40; i++) begin
      int op = $urandom % 4;
      int len = ($urandom % 3 == 0) ? (1 + $urandom % (MINC - 1)) : (MINC + $urandom % 6);
      if (op < 2)
        do_write($urandom % 2, 8'($urandom), len, ($urandom % 5) != 0);
      else
        do_xfer(len, ($urandom % 4) != 0, ($urandom % 4) != 0);
      check_state("R2");
    end

    // R8 no pulse ever lasted more than one cycle
    check("R8", {31'h0, wide_seen}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule